// File: doc/BRIEF.md
# Signed Averaging Add/Subtract Unit

This block takes two signed operands and returns half of their sum, or half of their difference, for one element. The element width is chosen at run time, one request at a time, from four sizes starting at 8 bits and doubling each step. The halving uses the exact sum, which carries one bit more than the widest element. As a result the intermediate value never overflows, and the 64-bit case needs no separate overflow fix-up.

The bit dropped by the halving is resolved by one of four rounding modes, named by a 2-bit input. The rounded value is wrapped to the element width and sign-extended across the full output word. The result and its valid flag are registered, so there is one cycle from request to answer. Masking, vector length, register-file access and choosing where the operands come from are handled by the caller.

Top module: `avg_addsub`

## Requirements
- R1: With op_i = 0 the unit forms a + b at full precision, shifts it right arithmetically by one and adds the rounding increment.
- R2: With op_i = 1 the unit forms a − b (a minus b, never b minus a) and then treats it exactly as in R1.
- R3: rm_i = 2'b00 (nearest, ties up): the increment equals bit 0 of the full-precision value, which is the bit shifted out.
- R4: rm_i = 2'b01 (nearest, ties to even): the increment is bit 0 AND bit 1 of the full-precision value, so an inexact result always has a 0 LSB.
- R5: rm_i = 2'b10 (truncate): the increment is always zero, giving the floor of the exact half.
- R6: rm_i = 2'b11 (round to odd): the increment is 1 only when bit 1 is 0 and bit 0 is 1, so an inexact result always has a 1 LSB.
- R7: width_i selects the element width: 2'b00 = 8, 2'b01 = 16, 2'b10 = 32, 2'b11 = 64 bits. Only the low element-width bits of a_i and b_i are used, as signed values, and the bits above them have no effect.
- R8: The rounded value is wrapped to the element width and sign-extended to all 64 output bits. For example, 8-bit 0x7F − 0x80 with rm_i = 2'b00 gives 0xFFFF_FFFF_FFFF_FF80.
- R9: At 64 bits no intermediate overflow occurs. Most-negative + most-negative gives 0x8000_0000_0000_0000, and most-positive − most-negative with truncation gives 0x7FFF_FFFF_FFFF_FFFF.
- R10: valid_o rises exactly one cycle after a cycle with valid_i high. res_o changes only on such a request and otherwise holds its value. A synchronous active-high rst clears both valid_o and res_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 1 | 0 = add, 1 = subtract (a − b) |
| width_i | input | 2 | Element width select |
| rm_i | input | 2 | Rounding mode |
| a_i | input | 64 | Operand a (low element-width bits used) |
| b_i | input | 64 | Operand b (low element-width bits used) |
| valid_o | output | 1 | Result valid, one cycle after request |
| res_o | output | 64 | Sign-extended averaged result |

## Verification
The rounding increment and the wrap to element width can both act in one cycle. This happens when the exact half is already the largest positive value and the dropped bit forces a carry, as in most-positive minus most-negative. The bench provokes this case at every width under all four rounding modes. It judges each result against a model built from the requirements and against literal expected words for the wrapped and non-wrapped outcomes. It also crosses the 64-bit extremes, where the exact sum needs its extra bit, with each rounding mode.

// File: rtl/avg_pkg.sv
package avg_pkg;
   typedef enum logic [1:0] {
      RM_NEAR_UP   = 2'd0,
      RM_NEAR_EVEN = 2'd1,
      RM_DOWN      = 2'd2,
      RM_ODD       = 2'd3
   } avg_rm_e;

   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } avg_op_e;
endpackage

// File: rtl/avg_sext.sv
// Picks the low element-width bits of din and sign-extends them to OUT_W.
module avg_sext #(
   parameter int IN_W  = 64,
   parameter int OUT_W = 65,
   parameter int MIN_W = 8,
   parameter int NUM_W = 4,
   parameter int SEL_W = 2
) (
   input  logic [IN_W-1:0]  din,
   input  logic [SEL_W-1:0] sel,
   output logic [OUT_W-1:0] dout
);
   localparam int TOP_W = MIN_W << (NUM_W - 1);

   if (NUM_W != (1 << SEL_W)) begin : g_bad_sel
      $error("avg_sext: NUM_W must equal 2**SEL_W");
   end
   if (IN_W < TOP_W || OUT_W < TOP_W) begin : g_bad_width
      $error("avg_sext: ports narrower than widest element");
   end

   logic [OUT_W-1:0] cand [NUM_W];

   for (genvar i = 0; i < NUM_W; i++) begin : g_width
      localparam int EW = MIN_W << i;
      assign cand[i] = OUT_W'(signed'(din[EW-1:0]));
   end

   always_comb begin
      dout = cand[sel];
   end
endmodule

// File: rtl/avg_round.sv
// Chooses the rounding increment from the retained LSB and the dropped bit.
module avg_round
   import avg_pkg::*;
(
   input  logic [1:0] rm,
   input  logic       kept_lsb,
   input  logic       dropped,
   output logic       inc
);
   always_comb begin
      unique case (avg_rm_e'(rm))
         RM_NEAR_UP:   inc = dropped;
         RM_NEAR_EVEN: inc = dropped & kept_lsb;
         RM_DOWN:      inc = 1'b0;
         RM_ODD:       inc = dropped & ~kept_lsb;
         default:      inc = 1'b0;
      endcase
   end
endmodule

// File: rtl/avg_addsub.sv
module avg_addsub
   import avg_pkg::*;
#(
   parameter int MIN_W = 8,
   parameter int NUM_W = 4
) (
   input  logic                                   clk,
   input  logic                                   rst,
   input  logic                                   valid_i,
   input  logic                                   op_i,
   input  logic [$clog2(NUM_W)-1:0]               width_i,
   input  logic [1:0]                             rm_i,
   input  logic [(MIN_W << (NUM_W - 1))-1:0]      a_i,
   input  logic [(MIN_W << (NUM_W - 1))-1:0]      b_i,
   output logic                                   valid_o,
   output logic [(MIN_W << (NUM_W - 1))-1:0]      res_o
);
   localparam int MAX_W = MIN_W << (NUM_W - 1);
   localparam int SEL_W = $clog2(NUM_W);
   localparam int EXT_W = MAX_W + 1;

   if (MIN_W < 2) begin : g_bad_min
      $error("avg_addsub: MIN_W must be at least 2");
   end
   if (NUM_W < 2 || (NUM_W & (NUM_W - 1)) != 0) begin : g_bad_num
      $error("avg_addsub: NUM_W must be a power of two, at least 2");
   end

   logic [EXT_W-1:0] ext_a, ext_b, full;
   logic [MAX_W-1:0] half, rounded, wrapped;
   logic             inc;
   logic [SEL_W-1:0] width_q;

   avg_sext #(.IN_W(MAX_W), .OUT_W(EXT_W), .MIN_W(MIN_W),
              .NUM_W(NUM_W), .SEL_W(SEL_W)) u_sext_a (
      .din(a_i), .sel(width_i), .dout(ext_a));

   avg_sext #(.IN_W(MAX_W), .OUT_W(EXT_W), .MIN_W(MIN_W),
              .NUM_W(NUM_W), .SEL_W(SEL_W)) u_sext_b (
      .din(b_i), .sel(width_i), .dout(ext_b));

   // exact sum/difference: one bit wider than the widest element
   always_comb begin
      if (avg_op_e'(op_i) == OP_SUB) full = ext_a - ext_b;
      else                           full = ext_a + ext_b;
   end

   assign half = full[EXT_W-1:1];

   avg_round u_round (
      .rm(rm_i), .kept_lsb(full[1]), .dropped(full[0]), .inc(inc));

   assign rounded = half + MAX_W'(inc);

   avg_sext #(.IN_W(MAX_W), .OUT_W(MAX_W), .MIN_W(MIN_W),
              .NUM_W(NUM_W), .SEL_W(SEL_W)) u_sext_res (
      .din(rounded), .sel(width_i), .dout(wrapped));

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o <= 1'b0;
         res_o   <= '0;
         width_q <= '0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) begin
            res_o   <= wrapped;
            width_q <= width_i;
         end
      end
   end

   // R10: one-cycle latency of the valid flag
   a_r10_valid_rise: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> valid_o);
   a_r10_valid_idle: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> !valid_o);
   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(res_o));

   // R4: ties-to-even leaves an even result whenever a bit was dropped
   a_r4_even: assert property (@(posedge clk) disable iff (rst)
      (valid_i && rm_i == RM_NEAR_EVEN && full[0]) |=> !res_o[0]);
   // R6: round-to-odd leaves an odd result whenever a bit was dropped
   a_r6_odd: assert property (@(posedge clk) disable iff (rst)
      (valid_i && rm_i == RM_ODD && full[0]) |=> res_o[0]);
   // R5: truncation keeps the retained LSB untouched
   a_r5_trunc: assert property (@(posedge clk) disable iff (rst)
      (valid_i && rm_i == RM_DOWN) |=> (res_o[0] == $past(full[1])));
   // R3: exact results are not adjusted in any mode
   a_r3_exact: assert property (@(posedge clk) disable iff (rst)
      (valid_i && !full[0]) |=> (res_o[0] == $past(full[1])));

   // R8: output is sign-extended from the element width in use
   for (genvar i = 0; i < NUM_W - 1; i++) begin : g_chk_ext
      localparam int EW = MIN_W << i;
      a_r8_sign_ext: assert property (@(posedge clk) disable iff (rst)
         (valid_o && width_q == SEL_W'(i)) |->
         (res_o[MAX_W-1:EW-1] == '0 || (&res_o[MAX_W-1:EW-1])));
   end
endmodule

// File: tb/avg_addsub_tb.sv
module avg_addsub_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic        valid_i;
   logic        op_i;
   logic [1:0]  width_i;
   logic [1:0]  rm_i;
   logic [63:0] a_i, b_i;
   logic        valid_o;
   logic [63:0] res_o;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   avg_addsub u_dut (
      .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
      .width_i(width_i), .rm_i(rm_i), .a_i(a_i), .b_i(b_i),
      .valid_o(valid_o), .res_o(res_o));

   function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                         logic sub, logic [1:0] w,
                                         logic [1:0] rm);
      int sh;
      logic signed [63:0] ta, tb, tr;
      logic signed [64:0] ea, eb, s, h;
      logic inc;
      sh = 64 - (8 << w);
      ta = a << sh;  ta = ta >>> sh;
      tb = b << sh;  tb = tb >>> sh;
      ea = ta;  eb = tb;
      s = sub ? ea - eb : ea + eb;
      case (rm)
         2'd0: inc = s[0];
         2'd1: inc = s[0] & s[1];
         2'd2: inc = 1'b0;
         default: inc = s[0] & ~s[1];
      endcase
      h = (s >>> 1) + 65'(inc);
      tr = h[63:0] << sh;
      tr = tr >>> sh;
      return tr;
   endfunction

   task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // drive one request at negedge, check at the following negedge
   task automatic run(string tag, logic [63:0] a, logic [63:0] b,
                      logic sub, logic [1:0] w, logic [1:0] rm,
                      logic [63:0] exp);
      valid_i = 1'b1; op_i = sub; width_i = w; rm_i = rm; a_i = a; b_i = b;
      @(negedge clk);
      valid_i = 1'b0;
      check({tag, " valid"}, {63'd0, valid_o}, 64'd1);
      check(tag, res_o, exp);
   endtask

   task automatic run_model(string tag, logic [63:0] a, logic [63:0] b,
                            logic sub, logic [1:0] w, logic [1:0] rm);
      run(tag, a, b, sub, w, rm, model(a, b, sub, w, rm));
   endtask

   task automatic test_reset();
      rst = 1'b1; valid_i = 1'b1; op_i = 0; width_i = 0; rm_i = 0;
      a_i = 64'h11; b_i = 64'h22;
      repeat (3) @(negedge clk);
      check("R10 reset valid", {63'd0, valid_o}, 64'd0);
      check("R10 reset data", res_o, 64'd0);
      valid_i = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      check("R10 idle valid", {63'd0, valid_o}, 64'd0);
   endtask

   task automatic test_modes_literal();
      // 5 + 2 = 7: half 3, dropped 1, kept 1
      run("R3 near_up 8b", 64'h05, 64'h02, 0, 2'd0, 2'd0, 64'd4);
      run("R4 near_even 8b", 64'h05, 64'h02, 0, 2'd0, 2'd1, 64'd4);
      run("R5 trunc 8b", 64'h05, 64'h02, 0, 2'd0, 2'd2, 64'd3);
      run("R6 odd 8b", 64'h05, 64'h02, 0, 2'd0, 2'd3, 64'd3);
      // 4 + 1 = 5: half 2, dropped 1, kept 0
      run("R4 near_even tie down", 64'h04, 64'h01, 0, 2'd0, 2'd1, 64'd2);
      run("R6 odd jam", 64'h04, 64'h01, 0, 2'd0, 2'd3, 64'd3);
      // -3 / 2 truncation floors toward minus infinity
      run("R5 trunc neg 16b", 64'hFFFD, 64'h0, 0, 2'd1, 2'd2,
          64'hFFFF_FFFF_FFFF_FFFE);
   endtask

   task automatic test_sub();
      run("R2 sub order", 64'd10, 64'd3, 1, 2'd2, 2'd2, 64'd3);
      run("R2 sub reverse", 64'd3, 64'd10, 1, 2'd2, 2'd2,
          64'hFFFF_FFFF_FFFF_FFFC);
      run("R1 add 32b", 64'd1000, 64'd2001, 0, 2'd2, 2'd0, 64'd1501);
   endtask

   task automatic test_sweep();
      logic [63:0] pa [4] = '{64'h7, 64'h1235, 64'h8000_0003, 64'hFFFF_FFFF_FFFF_FFF9};
      logic [63:0] pb [4] = '{64'hFA, 64'h8001, 64'h7FFF_FFFE, 64'h4};
      for (int w = 0; w < 4; w++)
         for (int rm = 0; rm < 4; rm++)
            for (int s = 0; s < 2; s++)
               for (int p = 0; p < 4; p++)
                  run_model($sformatf("R1 R2 R3 R4 R5 R6 sweep w=%0d rm=%0d sub=%0d p=%0d", w, rm, s, p),
                            pa[p], pb[p], s[0], w[1:0], rm[1:0]);
   endtask

   task automatic test_extremes();
      for (int w = 0; w < 4; w++) begin
         logic [63:0] mx, mn;
         int ew = 8 << w;
         mx = (64'd1 << (ew - 1)) - 64'd1;
         mn = ~mx;
         for (int rm = 0; rm < 4; rm++) begin
            run_model($sformatf("R8 R9 min+min w=%0d rm=%0d", w, rm), mn, mn, 0, w[1:0], rm[1:0]);
            run_model($sformatf("R8 R9 max-min w=%0d rm=%0d", w, rm), mx, mn, 1, w[1:0], rm[1:0]);
         end
      end
      run("R8 wrap 8b near_up", 64'h7F, 64'h80, 1, 2'd0, 2'd0,
          64'hFFFF_FFFF_FFFF_FF80);
      run("R8 no wrap 8b odd", 64'h7F, 64'h80, 1, 2'd0, 2'd3, 64'h7F);
      run("R9 64b min+min", 64'h8000_0000_0000_0000,
          64'h8000_0000_0000_0000, 0, 2'd3, 2'd0, 64'h8000_0000_0000_0000);
      run("R9 64b max-min trunc", 64'h7FFF_FFFF_FFFF_FFFF,
          64'h8000_0000_0000_0000, 1, 2'd3, 2'd2, 64'h7FFF_FFFF_FFFF_FFFF);
   endtask

   task automatic test_upper_ignored();
      run("R7 upper bits 8b", 64'hABCD_EF12_3456_7805, 64'h1111_2222_3333_4402,
          0, 2'd0, 2'd2, 64'd3);
      run("R7 upper bits 16b", 64'hDEAD_BEEF_0000_FFFE, 64'h1234_5678_9ABC_0000,
          0, 2'd1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
   endtask

   task automatic test_hold();
      logic [63:0] prev;
      run("R10 load", 64'd20, 64'd2, 0, 2'd2, 2'd2, 64'd11);
      prev = res_o;
      valid_i = 1'b0; a_i = 64'd99; b_i = 64'd77; rm_i = 2'd0;
      @(negedge clk);
      check("R10 idle valid low", {63'd0, valid_o}, 64'd0);
      check("R10 idle data held", res_o, prev);
      // back-to-back requests
      valid_i = 1'b1; op_i = 0; width_i = 2'd0; rm_i = 2'd2; a_i = 64'd8; b_i = 64'd2;
      @(negedge clk);
      check("R10 b2b first", res_o, 64'd5);
      a_i = 64'd40; b_i = 64'd0;
      @(negedge clk);
      valid_i = 1'b0;
      check("R10 b2b second", res_o, 64'd20);
      check("R10 b2b valid", {63'd0, valid_o}, 64'd1);
   endtask

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      failures++;
      checks++;
      $display("FAIL watchdog got=%0d exp=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      @(negedge clk);
      test_reset();
      test_modes_literal();
      test_sub();
      test_upper_ignored();
      test_extremes();
      test_sweep();
      test_hold();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule